// File: doc/BRIEF.md
# Paired-Register Double Operand Port

This block lets a 32-bit core with floating point kept in the integer registers work on 64-bit double-precision values. Each 64-bit operand lives in two adjacent 32-bit integer registers. The block holds the 32-entry register file as an even bank and an odd bank. It reads two source operands per issue and writes one result per write-back. It also keeps an accrued exception-flags register.

An issue presents a width flag and two source and one destination specifier. One clock later the block returns both operands as 64-bit values, or it raises an illegal-instruction indication if a double-precision access names an odd register. Write-back is a separate port. It carries the destination, the width, a 64-bit result and five exception flags. Register x0 behaves as a 64-bit zero source and a 64-bit discard sink, and it never touches x1 through its pair partner.

Top module: `dpair_regfile`

## Requirements
- R1: A legal double-precision issue returns, one clock later, op_a = {x[rs1+1], x[rs1]} and op_b = {x[rs2+1], x[rs2]}. The even register holds bits 31:0 and the next odd register holds bits 63:32.
- R2: A double-precision issue in which rs1, rs2 or rd has bit 0 set gives op_illegal = 1 one clock later, with op_a and op_b both zero.
- R3: A double-precision source specifier of 0 returns a 64-bit zero, whatever x1 holds.
- R4: A legal double-precision write-back to an even rd writes wb_data[31:0] into x[rd] and wb_data[63:32] into x[rd+1] on the same clock edge.
- R5: A double-precision write-back with rd = 0 changes neither x0 nor x1.
- R6: A single-precision issue reads one register of either parity. It returns that register in bits 31:0 and zero in bits 63:32. A specifier of 0 reads as zero.
- R7: A single-precision write-back writes wb_data[31:0] into x[rd] only. x1 may be written this way, and a write to x0 is discarded.
- R8: Every legal write-back ORs wb_flags[4:0] into acc_flags, including one whose rd is 0.
- R9: A double-precision write-back with an odd rd is illegal. It changes no register and leaves acc_flags unchanged.
- R10: After reset, acc_flags, op_valid and op_illegal are all zero.
- R11: op_valid is high exactly in the cycle after an issue. A single-precision issue never raises op_illegal, whatever the parity of its specifiers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | 1 | Issue request this cycle |
| iss_double | input | 1 | 1 = double-precision access, 0 = single |
| iss_rs1 | input | 5 | First source specifier |
| iss_rs2 | input | 5 | Second source specifier |
| iss_rd | input | 5 | Destination specifier (checked for parity) |
| op_valid | output | 1 | Operands valid (cycle after issue) |
| op_illegal | output | 1 | Illegal-instruction indication |
| op_a | output | 64 | First source operand |
| op_b | output | 64 | Second source operand |
| wb_valid | input | 1 | Write-back request |
| wb_double | input | 1 | Write-back width: 1 = 64-bit pair |
| wb_rd | input | 5 | Write-back destination |
| wb_data | input | 64 | Result value |
| wb_flags | input | 5 | Exception flags of the result |
| acc_flags | output | 5 | Accrued exception flags |

## Verification
A bank that writes the wrong half, or a wrong pair address, shows up at the next read of either register of the pair. The bench reads each pair both as one 64-bit value and as two single registers. A missing x0 or x1 guard only shows when x1 is read after a write to x0, so those reads follow at once. Errors in the parity checker or the flags path show in op_illegal one cycle after issue, or in acc_flags one cycle after write-back.

// File: rtl/dpr_pkg.sv
package dpr_pkg;
  // Per-source selection captured at issue, applied to the bank read data.
  typedef struct packed {
    logic dbl;   // pair access
    logic odd;   // specifier bit 0 (single access picks odd bank)
    logic zero;  // specifier is register 0
  } src_sel_t;
endpackage

// File: rtl/dpr_spec_check.sv
module dpr_spec_check #(
  parameter int NSPEC = 3
) (
  input  logic             dbl,
  input  logic [NSPEC-1:0] spec_lsb,
  output logic             illegal
);
  logic [NSPEC-1:0] odd_hit;

  for (genvar k = 0; k < NSPEC; k++) begin : g_spec
    assign odd_hit[k] = dbl & spec_lsb[k];
  end

  assign illegal = |odd_hit;
endmodule

// File: rtl/dpr_bank.sv
module dpr_bank #(
  parameter int DW    = 32,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr0,
  input  logic [AW-1:0] raddr1,
  output logic [DW-1:0] rdata0,
  output logic [DW-1:0] rdata1
);
  logic [DW-1:0] mem [0:DEPTH-1];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    rdata0 <= mem[raddr0];
    rdata1 <= mem[raddr1];
  end
endmodule

// File: rtl/dpr_flag_acc.sv
module dpr_flag_acc #(
  parameter int FW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          upd,
  input  logic [FW-1:0] flags_in,
  output logic [FW-1:0] acc
);
  always_ff @(posedge clk) begin
    if (rst)      acc <= '0;
    else if (upd) acc <= acc | flags_in;
  end

  // R8: accrued bits are never lost once set
  assert_flags_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((acc & $past(acc)) == $past(acc)));

  // R9: without an update the register holds
  assert_flags_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !upd |=> $stable(acc));
endmodule

// File: rtl/dpair_regfile.sv
module dpair_regfile #(
  parameter int XLEN   = 32,
  parameter int NREG   = 32,
  parameter int FLAG_W = 5,
  localparam int IDX_W = $clog2(NREG),
  localparam int BDEP  = NREG / 2,
  localparam int BAW   = IDX_W - 1,
  localparam int OPW   = 2 * XLEN
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              iss_valid,
  input  logic              iss_double,
  input  logic [IDX_W-1:0]  iss_rs1,
  input  logic [IDX_W-1:0]  iss_rs2,
  input  logic [IDX_W-1:0]  iss_rd,
  output logic              op_valid,
  output logic              op_illegal,
  output logic [OPW-1:0]    op_a,
  output logic [OPW-1:0]    op_b,
  input  logic              wb_valid,
  input  logic              wb_double,
  input  logic [IDX_W-1:0]  wb_rd,
  input  logic [OPW-1:0]    wb_data,
  input  logic [FLAG_W-1:0] wb_flags,
  output logic [FLAG_W-1:0] acc_flags
);
  import dpr_pkg::*;

  localparam int NSRC  = 2;
  localparam int NBANK = 2;

  // ---------------- issue side ----------------
  logic iss_bad;
  dpr_spec_check #(.NSPEC(3)) u_iss_chk (
    .dbl      (iss_double),
    .spec_lsb ({iss_rs1[0], iss_rs2[0], iss_rd[0]}),
    .illegal  (iss_bad)
  );

  logic [IDX_W-1:0] src_idx [NSRC];
  assign src_idx[0] = iss_rs1;
  assign src_idx[1] = iss_rs2;

  src_sel_t src_sel_q [NSRC];
  logic     valid_q, illegal_q;

  for (genvar s = 0; s < NSRC; s++) begin : g_sel
    always_ff @(posedge clk) begin
      if (rst) src_sel_q[s] <= '0;
      else if (iss_valid) begin
        src_sel_q[s].dbl  <= iss_double;
        src_sel_q[s].odd  <= src_idx[s][0];
        src_sel_q[s].zero <= (src_idx[s] == '0);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q   <= 1'b0;
      illegal_q <= 1'b0;
    end else begin
      valid_q   <= iss_valid;
      illegal_q <= iss_valid & iss_bad;
    end
  end

  // ---------------- write side ----------------
  logic wb_bad;
  dpr_spec_check #(.NSPEC(1)) u_wb_chk (
    .dbl      (wb_double),
    .spec_lsb (wb_rd[0]),
    .illegal  (wb_bad)
  );

  logic           wb_ok, wb_nz;
  logic           bank_we    [NBANK];
  logic [XLEN-1:0] bank_wdata [NBANK];

  assign wb_ok = wb_valid & ~wb_bad;
  assign wb_nz = (wb_rd != '0);

  always_comb begin
    // even bank: pair low half, or single even non-zero register
    bank_we[0]    = wb_ok & wb_nz & (wb_double | ~wb_rd[0]);
    bank_wdata[0] = wb_data[XLEN-1:0];
    // odd bank: pair high half (never for pair x0), or single odd register
    bank_we[1]    = wb_ok & (wb_double ? wb_nz : wb_rd[0]);
    bank_wdata[1] = wb_double ? wb_data[OPW-1:XLEN] : wb_data[XLEN-1:0];
  end

  // ---------------- storage ----------------
  logic [XLEN-1:0] bank_q [NBANK][NSRC];

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    dpr_bank #(.DW(XLEN), .DEPTH(BDEP)) u_bank (
      .clk    (clk),
      .we     (bank_we[b]),
      .waddr  (wb_rd[IDX_W-1:1]),
      .wdata  (bank_wdata[b]),
      .raddr0 (iss_rs1[IDX_W-1:1]),
      .raddr1 (iss_rs2[IDX_W-1:1]),
      .rdata0 (bank_q[b][0]),
      .rdata1 (bank_q[b][1])
    );
  end

  // ---------------- operand assembly ----------------
  function automatic logic [OPW-1:0] assemble(input src_sel_t sel, input logic kill,
                                              input logic [XLEN-1:0] ev,
                                              input logic [XLEN-1:0] od);
    if (kill || sel.zero) return '0;
    if (sel.dbl)          return {od, ev};
    return {{XLEN{1'b0}}, (sel.odd ? od : ev)};
  endfunction

  logic [OPW-1:0] src_val [NSRC];
  for (genvar s = 0; s < NSRC; s++) begin : g_asm
    assign src_val[s] = assemble(src_sel_q[s], illegal_q, bank_q[0][s], bank_q[1][s]);
  end

  assign op_valid   = valid_q;
  assign op_illegal = illegal_q;
  assign op_a       = src_val[0];
  assign op_b       = src_val[1];

  // ---------------- flags ----------------
  dpr_flag_acc #(.FW(FLAG_W)) u_flags (
    .clk      (clk),
    .rst      (rst),
    .upd      (wb_ok),
    .flags_in (wb_flags),
    .acc      (acc_flags)
  );

  // ---------------- assertions ----------------
  assert_odd_pair_trap_R2: assert property (@(posedge clk) disable iff (rst)
    (iss_valid && iss_double && (iss_rs1[0] || iss_rs2[0] || iss_rd[0]))
      |=> (op_valid && op_illegal));

  assert_trap_zero_ops_R2: assert property (@(posedge clk) disable iff (rst)
    op_illegal |-> (op_a == '0 && op_b == '0));

  assert_x0_source_R3: assert property (@(posedge clk) disable iff (rst)
    (iss_valid && iss_rs1 == '0) |=> (op_a == '0));

  assert_single_upper_R6: assert property (@(posedge clk) disable iff (rst)
    (iss_valid && !iss_double) |=> (op_a[OPW-1:XLEN] == '0 && op_b[OPW-1:XLEN] == '0));

  assert_valid_follows_R11: assert property (@(posedge clk) disable iff (rst)
    iss_valid |=> op_valid);

  assert_valid_idle_R11: assert property (@(posedge clk) disable iff (rst)
    !iss_valid |=> !op_valid);

  assert_single_no_trap_R11: assert property (@(posedge clk) disable iff (rst)
    (iss_valid && !iss_double) |=> !op_illegal);

  assert_x0_sink_R5: assert property (@(posedge clk) disable iff (rst)
    (wb_valid && wb_rd == '0) |-> (!bank_we[0] && !(wb_double && bank_we[1])));

  assert_bad_wb_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    (wb_valid && wb_double && wb_rd[0]) |-> (!bank_we[0] && !bank_we[1]));
endmodule

// File: tb/dpair_regfile_tb.sv
module dpair_regfile_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        iss_valid, iss_double;
  logic [4:0]  iss_rs1, iss_rs2, iss_rd;
  logic        op_valid, op_illegal;
  logic [63:0] op_a, op_b;
  logic        wb_valid, wb_double;
  logic [4:0]  wb_rd;
  logic [63:0] wb_data;
  logic [4:0]  wb_flags;
  logic [4:0]  acc_flags;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] model [32];
  logic [4:0]  flag_model;

  always #(CLK_PERIOD/2) clk = ~clk;

  dpair_regfile u_dut (
    .clk(clk), .rst(rst),
    .iss_valid(iss_valid), .iss_double(iss_double),
    .iss_rs1(iss_rs1), .iss_rs2(iss_rs2), .iss_rd(iss_rd),
    .op_valid(op_valid), .op_illegal(op_illegal), .op_a(op_a), .op_b(op_b),
    .wb_valid(wb_valid), .wb_double(wb_double), .wb_rd(wb_rd),
    .wb_data(wb_data), .wb_flags(wb_flags), .acc_flags(acc_flags)
  );

  typedef struct packed {
    logic       dbl;
    logic [4:0] rs1;
    logic [4:0] rs2;
    logic [4:0] rd;
    logic       ill;
  } vec_t;

  localparam int NVEC = 12;
  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 5'd2,  5'd4,  5'd6,  1'b0},  // R1
    '{1'b1, 5'd30, 5'd28, 5'd0,  1'b0},  // R1
    '{1'b1, 5'd0,  5'd8,  5'd10, 1'b0},  // R3
    '{1'b1, 5'd3,  5'd4,  5'd6,  1'b1},  // R2 odd rs1
    '{1'b1, 5'd2,  5'd5,  5'd6,  1'b1},  // R2 odd rs2
    '{1'b1, 5'd2,  5'd4,  5'd7,  1'b1},  // R2 odd rd
    '{1'b0, 5'd1,  5'd3,  5'd5,  1'b0},  // R6/R11 odd single
    '{1'b0, 5'd0,  5'd31, 5'd1,  1'b0},  // R6
    '{1'b0, 5'd2,  5'd4,  5'd6,  1'b0},  // R6
    '{1'b1, 5'd0,  5'd0,  5'd0,  1'b0},  // R3
    '{1'b0, 5'd31, 5'd30, 5'd0,  1'b0},  // R6
    '{1'b1, 5'd16, 5'd14, 5'd12, 1'b0}   // R1
  };

  function automatic logic [31:0] pat(input int i);
    return (32'(i) * 32'h0103_0507) ^ 32'hC0FF_EE00;
  endfunction

  function automatic logic [63:0] exp_src(input logic dbl, input logic [4:0] idx, input logic ill);
    if (ill || idx == 5'd0) return 64'd0;
    if (dbl) return {model[idx + 5'd1], model[idx]};
    return {32'd0, model[idx]};
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic dbl, input logic [4:0] r1, input logic [4:0] r2, input logic [4:0] rd);
    @(negedge clk);
    iss_valid = 1'b1; iss_double = dbl; iss_rs1 = r1; iss_rs2 = r2; iss_rd = rd;
    @(negedge clk);
    iss_valid = 1'b0;
  endtask

  task automatic wback(input logic dbl, input logic [4:0] rd, input logic [63:0] d, input logic [4:0] f);
    @(negedge clk);
    wb_valid = 1'b1; wb_double = dbl; wb_rd = rd; wb_data = d; wb_flags = f;
    @(negedge clk);
    wb_valid = 1'b0;
  endtask

  task automatic read_single(input string tag, input logic [4:0] r);
    issue(1'b0, r, r, 5'd0);
    check(tag, op_a, exp_src(1'b0, r, 1'b0));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst = 1'b1; iss_valid = 1'b0; iss_double = 1'b0; iss_rs1 = '0; iss_rs2 = '0; iss_rd = '0;
    wb_valid = 1'b0; wb_double = 1'b0; wb_rd = '0; wb_data = '0; wb_flags = '0;
    flag_model = '0;
    for (int i = 0; i < 32; i++) model[i] = 32'd0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R10 reset state
    check("R10 acc_flags", 64'(acc_flags), 64'd0);
    check("R10 op_valid", 64'(op_valid), 64'd0);
    check("R10 op_illegal", 64'(op_illegal), 64'd0);

    // fill all registers singly (R7 path), x0 write discarded
    for (int i = 0; i < 32; i++) begin
      wback(1'b0, 5'(i), {32'hFFFF_FFFF, pat(i)}, 5'd0);
      if (i != 0) model[i] = pat(i);
    end

    // vector table
    for (int v = 0; v < NVEC; v++) begin
      issue(VECS[v].dbl, VECS[v].rs1, VECS[v].rs2, VECS[v].rd);
      check($sformatf("R1/R2/R3/R6 vec%0d valid R11", v), 64'(op_valid), 64'd1);
      check($sformatf("R2 vec%0d illegal", v), 64'(op_illegal), 64'(VECS[v].ill));
      check($sformatf("R1/R3/R6 vec%0d op_a", v), op_a, exp_src(VECS[v].dbl, VECS[v].rs1, VECS[v].ill));
      check($sformatf("R1/R3/R6 vec%0d op_b", v), op_b, exp_src(VECS[v].dbl, VECS[v].rs2, VECS[v].ill));
    end

    // R11 op_valid drops when no issue
    @(negedge clk);
    check("R11 op_valid idle", 64'(op_valid), 64'd0);

    // R4 pair write-back
    wback(1'b1, 5'd6, 64'hDEAD_BEEF_0123_4567, 5'b00001);
    model[6] = 32'h0123_4567; model[7] = 32'hDEAD_BEEF; flag_model |= 5'b00001;
    issue(1'b1, 5'd6, 5'd4, 5'd2);
    check("R4 pair read", op_a, 64'hDEAD_BEEF_0123_4567);
    read_single("R4 low half x6", 5'd6);
    read_single("R4 high half x7", 5'd7);
    read_single("R4 neighbour x8", 5'd8);
    check("R8 flags after pair write", 64'(acc_flags), 64'(flag_model));

    // R5 pair write to x0: x1 untouched, flags still accrue (R8)
    wback(1'b1, 5'd0, 64'hFFFF_FFFF_FFFF_FFFF, 5'b00100);
    flag_model |= 5'b00100;
    read_single("R5 x1 kept", 5'd1);
    issue(1'b1, 5'd0, 5'd2, 5'd4);
    check("R5 x0 pair zero", op_a, 64'd0);
    check("R8 flags with x0 target", 64'(acc_flags), 64'(flag_model));

    // R9 illegal pair write-back to odd rd
    wback(1'b1, 5'd9, 64'h1111_2222_3333_4444, 5'b10000);
    read_single("R9 x8 unchanged", 5'd8);
    read_single("R9 x9 unchanged", 5'd9);
    read_single("R9 x10 unchanged", 5'd10);
    check("R9 flags unchanged", 64'(acc_flags), 64'(flag_model));

    // R7 single writes: x1 writable, x0 discarded, upper data ignored
    wback(1'b0, 5'd1, 64'hABAB_ABAB_5555_AAAA, 5'b00010);
    model[1] = 32'h5555_AAAA; flag_model |= 5'b00010;
    read_single("R7 x1 written", 5'd1);
    read_single("R7 x0 neighbour x2", 5'd2);
    wback(1'b0, 5'd0, 64'h0000_0000_1234_5678, 5'b01000);
    flag_model |= 5'b01000;
    read_single("R7 x0 reads zero", 5'd0);
    read_single("R7 x1 after x0 write", 5'd1);
    issue(1'b1, 5'd0, 5'd0, 5'd0);
    check("R3 pair x0 ignores x1", op_a, 64'd0);
    check("R8 all flags", 64'(acc_flags), 64'(flag_model));

    // R7 single write to odd register leaves even partner
    wback(1'b0, 5'd11, 64'h0000_0000_CAFE_F00D, 5'b00000);
    model[11] = 32'hCAFE_F00D;
    issue(1'b1, 5'd10, 5'd10, 5'd10);
    check("R7 single odd in pair", op_a, {32'hCAFE_F00D, model[10]});

    // R10 reset again clears flags
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R10 flags cleared", 64'(acc_flags), 64'd0);
    check("R10 op_valid cleared", 64'(op_valid), 64'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule